// File: doc/BRIEF.md
# DS3 Transmit Frame Overhead Generator

The block builds the overhead bit stream for an outgoing DS3 M-frame. A free-running position counter steps through the 4760-bit frame: 7 subframes of 680 bits, each made of 8 blocks of 85 bits. Bit 0 of every block is an overhead slot and the other 84 bits carry payload. In each overhead slot the block puts out the right frame alignment (F), multiframe alignment (M), parity (P), X or C bit. It also raises a strobe so that the payload multiplexer downstream can merge the bit into the line stream.

Parity is the modulo-2 sum of the payload bits seen on a serial input during the previous frame. C-bit values come from a separate stuffing block and are passed straight through. Test controls can flip the last F bit, the last M bit or the P-bit parity sense. A one-shot request, armed by a rising edge, corrupts both P bits of exactly one frame. The X bits follow the inverse of the remote-alarm control.

Top module: `ds3_oh_gen`

## Requirements
- R1: While rst_ni is low and right after it is released, the position is subframe 0 (sub_idx_o=0), block 0 (blk_idx_o=0), and both oh_strobe_o and frame_start_o are high.
- R2: oh_strobe_o is high on one cycle in 85, and that cycle is the first cycle of a block. blk_idx_o counts 0..7 within a subframe and sub_idx_o counts 0..6 within a frame. frame_start_o is high only at subframe 0, block 0, bit 0, so it repeats every 4760 cycles.
- R3: The F bits sit in blocks 1, 3, 5 and 7 and carry 1, 0, 0, 1 in that order. While f_inv_i is high, the block 7 bit is 0.
- R4: The M bits sit in block 0 of subframes 4, 5 and 6 (0-based) and carry 0, 1, 0. While m_inv_i is high, the subframe 6 bit is 1.
- R5: The X bits sit in block 0 of subframes 0 and 1 and equal the inverse of rai_send_i.
- R6: The P bits sit in block 0 of subframes 2 and 3. Both equal the XOR of pay_bit_i taken over every non-overhead cycle of the previous frame. In the first frame after reset they are 0.
- R7: While p_inv_i is high, both P bits are inverted (odd parity).
- R8: A cycle with err_ins_i high after a low cycle, while p_err_en_i is high, inverts both P bits of the frame that follows, for that frame only. A held-high err_ins_i does nothing more. A rising edge while p_err_en_i is low does nothing.
- R9: In blocks 2, 4 and 6 the overhead bit equals c_bit_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| f_inv_i | input | 1 | Flip the fourth F bit |
| m_inv_i | input | 1 | Flip the third M bit |
| p_inv_i | input | 1 | Send odd parity on P bits |
| p_err_en_i | input | 1 | Enable the one-shot P corruption |
| err_ins_i | input | 1 | One-shot request, acts on a rising edge |
| rai_send_i | input | 1 | Remote alarm send; X bits carry its inverse |
| c_bit_i | input | 1 | C-bit value from the stuffing block |
| pay_bit_i | input | 1 | Serial payload bit, used for parity |
| oh_bit_o | output | 1 | Overhead bit, valid while oh_strobe_o is high |
| oh_strobe_o | output | 1 | Marks the overhead slot of each block |
| frame_start_o | output | 1 | First bit of the M-frame |
| sub_idx_o | output | 3 | Subframe index 0..6 |
| blk_idx_o | output | 3 | Block index 0..7 within the subframe |

## Verification
The assertion that both P bits of a frame agree assumes that p_inv_i, p_err_en_i and err_ins_i do not change between the two P slots of one frame. The bench changes its controls only on frame boundaries. The only exception is err_ins_i, which it raises mid-frame after both P slots have passed. The assertions on the F, X and C bits assume that the inputs are steady through the sampled cycle. The bench drives every input on the falling clock edge.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;
  localparam int unsigned DS3_SUBFRAMES  = 7;
  localparam int unsigned DS3_BLOCKS     = 8;
  localparam int unsigned DS3_BLOCK_BITS = 85;
  // overhead slot roles in block 0, by subframe
  localparam int unsigned X_LAST_SUB = 1;
  localparam int unsigned P_LAST_SUB = 3;
endpackage

// File: rtl/ds3_oh_pos_cnt.sv
module ds3_oh_pos_cnt #(
  parameter int unsigned SUBFRAMES  = ds3_oh_pkg::DS3_SUBFRAMES,
  parameter int unsigned BLOCKS     = ds3_oh_pkg::DS3_BLOCKS,
  parameter int unsigned BLOCK_BITS = ds3_oh_pkg::DS3_BLOCK_BITS,
  localparam int unsigned SW = $clog2(SUBFRAMES),
  localparam int unsigned BW = $clog2(BLOCKS),
  localparam int unsigned PW = $clog2(BLOCK_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] sub_o,
  output logic [BW-1:0] blk_o,
  output logic          oh_slot_o,
  output logic          frame_start_o,
  output logic          frame_last_o
);
  logic [PW-1:0] bit_q;
  logic [BW-1:0] blk_q;
  logic [SW-1:0] sub_q;
  logic bit_last, blk_last, sub_last;

  assign bit_last = (bit_q == PW'(BLOCK_BITS - 1));
  assign blk_last = (blk_q == BW'(BLOCKS - 1));
  assign sub_last = (sub_q == SW'(SUBFRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else if (bit_last) begin
      bit_q <= '0;
      if (blk_last) begin
        blk_q <= '0;
        sub_q <= sub_last ? '0 : sub_q + 1'b1;
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign sub_o         = sub_q;
  assign blk_o         = blk_q;
  assign oh_slot_o     = (bit_q == '0);
  assign frame_start_o = (bit_q == '0) && (blk_q == '0) && (sub_q == '0);
  assign frame_last_o  = bit_last && blk_last && sub_last;

  p_bit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_last |=> bit_q == $past(bit_q) + PW'(1));
  p_bit_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_last |=> bit_q == '0);
  p_sub_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q < SW'(SUBFRAMES));
  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_o |=> frame_start_o);
endmodule

// File: rtl/ds3_oh_parity.sv
module ds3_oh_parity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pay_bit_i,
  input  logic pay_valid_i,
  input  logic frame_last_i,
  output logic par_o
);
  logic acc_q, par_q, acc_nxt;

  assign acc_nxt = acc_q ^ (pay_valid_i & pay_bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (frame_last_i) begin
      acc_q <= 1'b0;
      par_q <= acc_nxt;
    end else begin
      acc_q <= acc_nxt;
    end
  end

  assign par_o = par_q;

  p_par_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_last_i |=> $stable(par_q));
  p_acc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_i |=> !acc_q);
endmodule

// File: rtl/ds3_oh_err_inj.sv
module ds3_oh_err_inj (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_ins_i,
  input  logic en_i,
  input  logic frame_last_i,
  output logic err_act_o
);
  logic ins_q, pend_q, act_q, rise;

  assign rise = err_ins_i & ~ins_q & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      ins_q <= err_ins_i;
      if (frame_last_i) begin
        act_q  <= pend_q | rise;
        pend_q <= 1'b0;
      end else if (rise) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign err_act_o = act_q;

  p_err_arm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(frame_last_i));
  p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_last_i |=> $stable(act_q));
endmodule

// File: rtl/ds3_oh_gen.sv
module ds3_oh_gen #(
  parameter int unsigned SUBFRAMES  = ds3_oh_pkg::DS3_SUBFRAMES,
  parameter int unsigned BLOCKS     = ds3_oh_pkg::DS3_BLOCKS,
  parameter int unsigned BLOCK_BITS = ds3_oh_pkg::DS3_BLOCK_BITS,
  localparam int unsigned SW = $clog2(SUBFRAMES),
  localparam int unsigned BW = $clog2(BLOCKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          f_inv_i,
  input  logic          m_inv_i,
  input  logic          p_inv_i,
  input  logic          p_err_en_i,
  input  logic          err_ins_i,
  input  logic          rai_send_i,
  input  logic          c_bit_i,
  input  logic          pay_bit_i,
  output logic          oh_bit_o,
  output logic          oh_strobe_o,
  output logic          frame_start_o,
  output logic [SW-1:0] sub_idx_o,
  output logic [BW-1:0] blk_idx_o
);
  import ds3_oh_pkg::*;

  logic [SW-1:0] sub;
  logic [BW-1:0] blk;
  logic oh_slot, frame_last, par, err_act, oh_bit;

  ds3_oh_pos_cnt #(.SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS)) u_cnt (
    .clk_i, .rst_ni,
    .sub_o(sub), .blk_o(blk), .oh_slot_o(oh_slot),
    .frame_start_o(frame_start_o), .frame_last_o(frame_last)
  );

  ds3_oh_parity u_par (
    .clk_i, .rst_ni,
    .pay_bit_i, .pay_valid_i(~oh_slot), .frame_last_i(frame_last), .par_o(par)
  );

  ds3_oh_err_inj u_err (
    .clk_i, .rst_ni,
    .err_ins_i, .en_i(p_err_en_i), .frame_last_i(frame_last), .err_act_o(err_act)
  );

  // block 0: X / P / M by subframe; odd blocks: F; even nonzero blocks: C
  always_comb begin
    oh_bit = 1'b0;
    if (blk == '0) begin
      if (sub <= SW'(X_LAST_SUB))      oh_bit = ~rai_send_i;
      else if (sub <= SW'(P_LAST_SUB)) oh_bit = par ^ p_inv_i ^ err_act;
      else if (sub == SW'(P_LAST_SUB + 2)) oh_bit = 1'b1;
      else if (sub == SW'(P_LAST_SUB + 3)) oh_bit = m_inv_i;
      else                             oh_bit = 1'b0;
    end else if (blk[0]) begin
      if (blk == BW'(1))                    oh_bit = 1'b1;
      else if (blk == BW'(BLOCKS - 1))      oh_bit = ~f_inv_i;
      else                                  oh_bit = 1'b0;
    end else begin
      oh_bit = c_bit_i;
    end
  end

  assign oh_bit_o    = oh_bit;
  assign oh_strobe_o = oh_slot;
  assign sub_idx_o   = sub;
  assign blk_idx_o   = blk;

  // first P bit of the frame, kept for the pair check
  logic p_first_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_first_q <= 1'b0;
    else if (oh_slot && blk == '0 && sub == SW'(P_LAST_SUB - 1)) p_first_q <= oh_bit_o;
  end

  p_start_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> oh_strobe_o && sub_idx_o == '0 && blk_idx_o == '0);
  p_f_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_strobe_o && blk_idx_o == BW'(1) |-> oh_bit_o);
  p_m_mid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_strobe_o && blk_idx_o == '0 && sub_idx_o == SW'(5) |-> oh_bit_o);
  p_x_rai_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_strobe_o && blk_idx_o == '0 && sub_idx_o < SW'(2) |-> oh_bit_o == !rai_send_i);
  p_p_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_strobe_o && blk_idx_o == '0 && sub_idx_o == SW'(3) |-> oh_bit_o == p_first_q);
  p_c_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_strobe_o && blk_idx_o != '0 && !blk_idx_o[0] |-> oh_bit_o == c_bit_i);
endmodule

// File: tb/ds3_oh_gen_tb_top.sv
`timescale 1ns/1ps
module ds3_oh_gen_tb_top;
  localparam int FRAME = 4760;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic rst_ni, f_inv_i, m_inv_i, p_inv_i, p_err_en_i, err_ins_i, rai_send_i, c_bit_i, pay_bit_i;
  logic oh_bit_o, oh_strobe_o, frame_start_o;
  logic [2:0] sub_idx_o, blk_idx_o;

  ds3_oh_gen dut_i (
    .clk_i, .rst_ni, .f_inv_i, .m_inv_i, .p_inv_i, .p_err_en_i, .err_ins_i,
    .rai_send_i, .c_bit_i, .pay_bit_i, .oh_bit_o, .oh_strobe_o, .frame_start_o,
    .sub_idx_o, .blk_idx_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc, err_frame, acc, prev_par, prev_err;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp_v);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    err_ins_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(oh_strobe_o && frame_start_o && sub_idx_o == 0 && blk_idx_o == 0, "R1 in reset",
        {frame_start_o, oh_strobe_o, sub_idx_o, blk_idx_o}, 8'hC0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc = 0; acc = 0; prev_par = 0; err_frame = -1; prev_err = 0;
    #1;
    chk(oh_strobe_o && frame_start_o && sub_idx_o == 0 && blk_idx_o == 0, "R1 after release",
        {frame_start_o, oh_strobe_o, sub_idx_o, blk_idx_o}, 8'hC0);
  endtask

  // one cycle: drive at falling edge, check, account for payload
  task automatic run_cycle();
    int pos, bitp, blk, sub, frm, e;
    string req;
    pos = cyc % FRAME; bitp = pos % 85; blk = (pos / 85) % 8; sub = pos / 680; frm = cyc / FRAME;
    c_bit_i = 1'($urandom);
    pay_bit_i = 1'($urandom);
    #1;
    chk(oh_strobe_o == (bitp == 0), "R2 strobe", oh_strobe_o, bitp == 0);
    if (bitp == 0) begin
      chk(frame_start_o == (pos == 0), "R2 frame start", frame_start_o, pos == 0);
      chk(sub_idx_o == sub && blk_idx_o == blk, "R2 position",
          sub_idx_o * 8 + blk_idx_o, sub * 8 + blk);
      if (blk == 0) begin
        if (sub < 2) begin e = !rai_send_i; req = "R5 X bit"; end
        else if (sub < 4) begin
          e = prev_par ^ p_inv_i ^ (frm == err_frame);
          req = (frm == err_frame) ? "R8 P bit" : (p_inv_i ? "R7 P bit" : "R6 P bit");
        end
        else begin e = (sub == 5) ? 1 : (sub == 6) ? m_inv_i : 0; req = "R4 M bit"; end
      end else if (blk % 2 == 1) begin
        e = (blk == 1) ? 1 : (blk == 7) ? !f_inv_i : 0; req = "R3 F bit";
      end else begin
        e = c_bit_i; req = "R9 C bit";
      end
      chk(oh_bit_o == e, req, oh_bit_o, e);
    end else begin
      acc ^= pay_bit_i;
      chk(!frame_start_o, "R2 frame start", frame_start_o, 0);
    end
    if (err_ins_i && !prev_err && p_err_en_i) err_frame = frm + 1;
    prev_err = err_ins_i;
    if (pos == FRAME - 1) begin prev_par = acc; acc = 0; end
    @(negedge clk_i);
    cyc++;
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * FRAME; i++) run_cycle();
  endtask

  task automatic t_normal();
    f_inv_i = 0; m_inv_i = 0; p_inv_i = 0; rai_send_i = 0; p_err_en_i = 0;
    run_frames(2);   // R1 R2 R3 R4 R5 R6 R9
  endtask

  task automatic t_rai();
    rai_send_i = 1;  // R5
    run_frames(1);
    rai_send_i = 0;
  endtask

  task automatic t_inversions();
    f_inv_i = 1; m_inv_i = 1; p_inv_i = 1;  // R3 R4 R7
    run_frames(2);
    f_inv_i = 0; m_inv_i = 0; p_inv_i = 0;
  endtask

  task automatic t_err_oneshot();
    p_err_en_i = 1;   // R8: raise after both P slots, hold for several frames
    for (int i = 0; i < 3000; i++) run_cycle();
    err_ins_i = 1;
    for (int i = 0; i < FRAME - 3000 + 2 * FRAME; i++) run_cycle();
    err_ins_i = 0;
    run_frames(1);
  endtask

  task automatic t_err_disabled();
    p_err_en_i = 0;   // R8: edge ignored while disabled, level ignored when enabled later
    for (int i = 0; i < 3000; i++) run_cycle();
    err_ins_i = 1;
    for (int i = 0; i < FRAME - 3000; i++) run_cycle();
    p_err_en_i = 1;
    run_frames(2);
    err_ins_i = 0; p_err_en_i = 0;
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 1234; i++) run_cycle();
    do_reset();       // R1 mid-frame
    run_frames(1);
  endtask

  initial begin
    f_inv_i = 0; m_inv_i = 0; p_inv_i = 0; p_err_en_i = 0; err_ins_i = 0;
    rai_send_i = 0; c_bit_i = 0; pay_bit_i = 0; rst_ni = 0;
    do_reset();
    t_normal();
    t_rai();
    t_inversions();
    t_err_oneshot();
    t_err_disabled();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule